// File: doc/BRIEF.md
# Mailbox command sequencer

This engine runs one complete command exchange with a service microcontroller through a pair of mailbox FIFOs reached over a simple register port. A caller supplies an opcode byte, an argument count, a response count and up to eight argument bytes, then pulses start. The engine first reads the mailbox status register and writes that value back, which clears stale flags. It then sends the opcode and the arguments, consumes one acknowledge word, and collects the requested response bytes into an output buffer.

Each outgoing byte waits for room in the transmit FIFO. Each incoming word waits for data in the receive FIFO and is followed by a status write that clears the receive flag. Every wait is bounded. When a bound runs out, the access goes ahead anyway and a sticky timeout flag is raised. The first two response bytes are also presented as a 16-bit word with the first byte in the upper half, which suits two-byte status queries such as opcode 0x0C or 0x11 with no arguments.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and reg_req_o are 0, and resp_o and status_word_o are 0.
- R2: A start accepted in idle begins with a read of the status register (reg_addr_o = 2). The next access writes that same value back to the status register.
- R3: The opcode is written to the data register (reg_addr_o = 1) as the first data write, in bits 15:8 of reg_wdata_o with all other bits 0.
- R4: The argument bytes follow the opcode in buffer order, byte k being args_i[8k+7:8k], each in bits 15:8 of its own data write.
- R5: Before every data write, the status register is read until bit 1 (transmit not full) is 1, with at most POLL_LIMIT reads. If the limit is reached, the write still happens and timeout_o goes to 1 and stays 1 until reset.
- R6: After the last argument, exactly one data read is made and its value is discarded. Every data read is followed at once by a status write of value 0x4.
- R7: Before every data read, the status register is read until bit 2 (receive not empty) is 1, with the same POLL_LIMIT bound and the same timeout behaviour.
- R8: Response byte k is bits 15:8 of the k-th data read after the acknowledge, and appears on resp_o[8k+7:8k]. Unused bytes read 0 after a new start.
- R9: status_word_o equals {response byte 0, response byte 1}.
- R10: A start pulse while busy_o is 1 has no effect on the bus traffic or the results.
- R11: busy_o is 1 from the cycle after an accepted start until the end of the transaction. done_o pulses exactly once, in the last busy cycle.
- R12: Counts above 8 are treated as 8: 8 argument writes and 8 response reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only in idle |
| opcode_i | input | 8 | Command opcode |
| in_cnt_i | input | 4 | Number of argument bytes |
| out_cnt_i | input | 4 | Number of response bytes |
| args_i | input | 64 | Argument bytes, byte k in bits 8k+7:8k |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky: some wait hit its bound |
| resp_o | output | 64 | Response bytes, byte k in bits 8k+7:8k |
| status_word_o | output | 16 | First response byte high, second low |
| reg_req_o | output | 1 | Register access this cycle |
| reg_we_o | output | 1 | Access is a write |
| reg_addr_o | output | 2 | 1 = data, 2 = status |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid in the access cycle |

## Verification
The hardest situation to reach is a wait that runs out, because the FIFO model has to withhold a flag for the full poll bound. The mailbox model in the bench holds each flag low for a programmable number of status reads. That count is reloaded after every other access. A stall longer than the bound forces the transmit wait, and in a separate run the receive wait, to give up after exactly POLL_LIMIT reads. The same stall counters drive short waits in the vector table, so the number of status reads the engine makes can be predicted exactly for every transaction.

// File: rtl/mbx_cmd_seq_pkg.sv
package mbx_cmd_seq_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam int STAT_TXNF  = 1;
  localparam int STAT_RXNE  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_SEND_OP, ST_SEND_ARG, ST_GET_ACK, ST_GET_RESP, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {PH_POLL, PH_XFER, PH_CLR} seq_phase_e;
endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // counts failed attempts; cleared whenever a poll is not failing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
    else              cnt_q <= '0;
  end

  assign expired_o = (cnt_q == LAST);

  assert_poll_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/mbx_arg_buf.sv
module mbx_arg_buf #(
  parameter int MAX_BYTES = 8,
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [7:0]             opcode_i,
  input  logic [8*MAX_BYTES-1:0] args_i,
  input  logic                   sel_op_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [31:0]            word_o
);
  logic [7:0] op_q;
  logic [7:0] arg_q [MAX_BYTES];
  logic [7:0] byte_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     op_q <= '0;
    else if (load_i) op_q <= opcode_i;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_arg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     arg_q[g] <= '0;
      else if (load_i) arg_q[g] <= args_i[8*g +: 8];
    end
  end

  assign byte_sel = sel_op_i ? op_q : arg_q[idx_i];
  assign word_o   = {16'h0000, byte_sel, 8'h00};

  assert_latch_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(op_q));
endmodule

// File: rtl/mbx_resp_buf.sv
module mbx_resp_buf #(
  parameter int MAX_BYTES = 8,
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             byte_i,
  output logic [8*MAX_BYTES-1:0] resp_o,
  output logic [15:0]            word_o
);
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_resp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 resp_o[8*g +: 8] <= '0;
      else if (clr_i)                              resp_o[8*g +: 8] <= '0;
      else if (we_i && (idx_i == IDX_W'(g)))       resp_o[8*g +: 8] <= byte_i;
    end
  end

  if (MAX_BYTES > 1) begin : g_word2
    assign word_o = {resp_o[7:0], resp_o[15:8]};
  end else begin : g_word1
    assign word_o = {resp_o[7:0], 8'h00};
  end

  assert_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i && idx_i == '0) |=> resp_o[7:0] == $past(byte_i));
endmodule

// File: rtl/mbx_seq_fsm.sv
module mbx_seq_fsm
  import mbx_cmd_seq_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  in_cnt_i,
  input  logic [CNT_W-1:0]  out_cnt_i,
  input  logic [REG_W-1:0]  reg_rdata_i,
  input  logic [REG_W-1:0]  tx_word_i,
  input  logic              expired_i,
  output logic              tmr_inc_o,
  output logic              load_o,
  output logic              sel_op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              resp_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [REG_W-1:0]  reg_wdata_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BYTES);
  localparam logic [REG_W-1:0] RXNE_CLR = REG_W'(1) << STAT_RXNE;

  seq_state_e       state_q;
  seq_phase_e       phase_q;
  logic [CNT_W-1:0] idx_q, n_in_q, n_out_q;
  logic [REG_W-1:0] clr_val_q;
  logic             timeout_q;

  logic tx_st, rx_st, polling, flag_ok, give_up;
  logic last_in, last_out;

  assign tx_st    = (state_q == ST_SEND_OP) || (state_q == ST_SEND_ARG);
  assign rx_st    = (state_q == ST_GET_ACK) || (state_q == ST_GET_RESP);
  assign polling  = (tx_st || rx_st) && (phase_q == PH_POLL);
  assign flag_ok  = tx_st ? reg_rdata_i[STAT_TXNF] : reg_rdata_i[STAT_RXNE];
  assign give_up  = !flag_ok && expired_i;
  assign last_in  = (idx_q == n_in_q - 1'b1);
  assign last_out = (idx_q == n_out_q - 1'b1);

  function automatic logic [CNT_W-1:0] sat(input logic [CNT_W-1:0] c);
    return (c > MAX_C) ? MAX_C : c;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_POLL;
      idx_q     <= '0;
      n_in_q    <= '0;
      n_out_q   <= '0;
      clr_val_q <= '0;
      timeout_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CLEAR;
          phase_q <= PH_POLL;
          idx_q   <= '0;
          n_in_q  <= sat(in_cnt_i);
          n_out_q <= sat(out_cnt_i);
        end
        ST_CLEAR: begin
          if (phase_q == PH_POLL) begin
            clr_val_q <= reg_rdata_i;
            phase_q   <= PH_XFER;
          end else begin
            state_q <= ST_SEND_OP;
            phase_q <= PH_POLL;
          end
        end
        ST_SEND_OP, ST_SEND_ARG: begin
          if (phase_q == PH_POLL) begin
            if (flag_ok || expired_i) phase_q <= PH_XFER;
            if (give_up) timeout_q <= 1'b1;
          end else begin
            phase_q <= PH_POLL;
            if (state_q == ST_SEND_OP) begin
              idx_q   <= '0;
              state_q <= (n_in_q != '0) ? ST_SEND_ARG : ST_GET_ACK;
            end else if (last_in) begin
              idx_q   <= '0;
              state_q <= ST_GET_ACK;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_GET_ACK, ST_GET_RESP: begin
          unique case (phase_q)
            PH_POLL: begin
              if (flag_ok || expired_i) phase_q <= PH_XFER;
              if (give_up) timeout_q <= 1'b1;
            end
            PH_XFER: phase_q <= PH_CLR;
            default: begin
              phase_q <= PH_POLL;
              if (state_q == ST_GET_ACK) begin
                idx_q   <= '0;
                state_q <= (n_out_q != '0) ? ST_GET_RESP : ST_DONE;
              end else if (last_out) begin
                state_q <= ST_DONE;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = ADDR_STAT;
    reg_wdata_o = '0;
    if (state_q == ST_CLEAR) begin
      reg_req_o   = 1'b1;
      reg_we_o    = (phase_q == PH_XFER);
      reg_wdata_o = (phase_q == PH_XFER) ? clr_val_q : '0;
    end else if (tx_st || rx_st) begin
      reg_req_o = 1'b1;
      unique case (phase_q)
        PH_POLL: ;
        PH_XFER: begin
          reg_addr_o  = ADDR_DATA;
          reg_we_o    = tx_st;
          reg_wdata_o = tx_st ? tx_word_i : '0;
        end
        default: begin
          reg_we_o    = 1'b1;
          reg_wdata_o = RXNE_CLR;
        end
      endcase
    end
  end

  assign tmr_inc_o = polling && !flag_ok && !expired_i;
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign sel_op_o  = (state_q == ST_SEND_OP);
  assign idx_o     = idx_q[IDX_W-1:0];
  assign resp_we_o = (state_q == ST_GET_RESP) && (phase_q == PH_XFER);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign timeout_o = timeout_q;

  assert_clear_writeback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLEAR && phase_q == PH_POLL) |=> reg_wdata_o == $past(reg_rdata_i));
  assert_write_after_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_st && phase_q == PH_POLL && reg_rdata_i[STAT_TXNF])
      |=> (reg_we_o && reg_addr_o == ADDR_DATA));
  assert_timeout_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);
  assert_rx_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_st && phase_q == PH_XFER)
      |=> (reg_we_o && reg_addr_o == ADDR_STAT && reg_wdata_o == RXNE_CLR));
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_CLEAR) |=> state_q != ST_CLEAR);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
  import mbx_cmd_seq_pkg::*;
#(
  parameter int MAX_BYTES  = 8,
  parameter int POLL_LIMIT = 10000,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [7:0]             opcode_i,
  input  logic [CNT_W-1:0]       in_cnt_i,
  input  logic [CNT_W-1:0]       out_cnt_i,
  input  logic [8*MAX_BYTES-1:0] args_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   timeout_o,
  output logic [8*MAX_BYTES-1:0] resp_o,
  output logic [15:0]            status_word_o,
  output logic                   reg_req_o,
  output logic                   reg_we_o,
  output logic [1:0]             reg_addr_o,
  output logic [31:0]            reg_wdata_o,
  input  logic [31:0]            reg_rdata_i
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic             tmr_inc, expired, load, sel_op, resp_we;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] tx_word;

  mbx_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (tmr_inc),
    .expired_o (expired)
  );

  mbx_arg_buf #(.MAX_BYTES(MAX_BYTES)) u_args (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .opcode_i (opcode_i),
    .args_i   (args_i),
    .sel_op_i (sel_op),
    .idx_i    (idx),
    .word_o   (tx_word)
  );

  mbx_resp_buf #(.MAX_BYTES(MAX_BYTES)) u_resp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .we_i   (resp_we),
    .idx_i  (idx),
    .byte_i (reg_rdata_i[15:8]),
    .resp_o (resp_o),
    .word_o (status_word_o)
  );

  mbx_seq_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .in_cnt_i    (in_cnt_i),
    .out_cnt_i   (out_cnt_i),
    .reg_rdata_i (reg_rdata_i),
    .tx_word_i   (tx_word),
    .expired_i   (expired),
    .tmr_inc_o   (tmr_inc),
    .load_o      (load),
    .sel_op_o    (sel_op),
    .idx_o       (idx),
    .resp_we_o   (resp_we),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .reg_req_o   (reg_req_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o)
  );
endmodule

// File: tb/mbx_cmd_seq_tb_top.sv
module mbx_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_LIMIT = 10000;
  localparam int NV = 4;
  localparam logic [7:0] ACK = 8'hA5;

  localparam logic [7:0]  V_OP   [NV] = '{8'h0C, 8'h11, 8'h2F, 8'h5A};
  localparam logic [3:0]  V_NIN  [NV] = '{4'd0, 4'd0, 4'd3, 4'd12};
  localparam logic [3:0]  V_NOUT [NV] = '{4'd2, 4'd2, 4'd1, 4'd9};
  localparam int          V_TXS  [NV] = '{0, 2, 1, 3};
  localparam int          V_RXS  [NV] = '{0, 0, 4, 1};
  localparam logic [63:0] V_ARGS [NV] = '{64'h0, 64'h0, 64'h0000_0000_00CC_BBAA,
                                          64'h8877_6655_4433_2211};
  localparam logic [63:0] V_RESP [NV] = '{64'h0000_0000_0000_1234, 64'h0000_0000_0000_0780,
                                          64'h0000_0000_0000_005C, 64'hF8F7_F6F5_F4F3_F2F1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = '0;
  logic [3:0] in_cnt = '0, out_cnt = '0;
  logic [63:0] args = '0;
  logic busy, done, timeout, req, we;
  logic [63:0] resp;
  logic [15:0] sword;
  logic [1:0] addr;
  logic [31:0] wdata, rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .in_cnt_i(in_cnt), .out_cnt_i(out_cnt), .args_i(args),
    .busy_o(busy), .done_o(done), .timeout_o(timeout), .resp_o(resp),
    .status_word_o(sword), .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  // mailbox model
  int tx_stall = 0, rx_stall = 0, tx_left = 0, rx_left = 0;
  logic [7:0] rxq [32];
  int rx_ptr = 0;
  logic [31:0] stat_val;
  assign stat_val = {28'h0, 1'b1, (rx_left == 0), (tx_left == 0), 1'b0};
  assign rdata = (addr == 2'd2) ? stat_val :
                 (addr == 2'd1) ? {16'h0, rxq[rx_ptr & 31], 8'h00} : 32'h0;

  // access log
  logic [31:0] dwr [32];
  int n_dwr = 0, n_drd = 0, n_srd = 0, n_clr4 = 0, n_swr_other = 0, n_acc = 0, n_done = 0;
  logic [31:0] first_rd_val = '0, wb_val = '0;
  logic first_is_srd = 1'b0, second_is_swr = 1'b0;
  logic p_v = 1'b0, p_we = 1'b0;
  logic [1:0] p_addr = '0;
  logic [31:0] p_wdata = '0;

  task automatic clear_log();
    n_dwr = 0; n_drd = 0; n_srd = 0; n_clr4 = 0; n_swr_other = 0; n_acc = 0; n_done = 0;
    first_is_srd = 0; second_is_swr = 0; rx_ptr = 0;
    tx_left = tx_stall; rx_left = rx_stall;
  endtask

  always @(negedge clk) begin
    if (p_v) begin
      if (!p_we && p_addr == 2'd2) begin
        if (tx_left > 0) tx_left--;
        if (rx_left > 0) rx_left--;
      end else begin
        if (p_we && p_addr == 2'd1) begin dwr[n_dwr & 31] = p_wdata; n_dwr++; end
        if (!p_we && p_addr == 2'd1) begin rx_ptr++; n_drd++; end
        if (p_we && p_addr == 2'd2) begin
          if (p_wdata == 32'h4) n_clr4++;
          else n_swr_other++;
        end
        tx_left = tx_stall; rx_left = rx_stall;
      end
    end
    p_v = req; p_we = we; p_addr = addr; p_wdata = wdata;
    if (done) n_done++;
    if (req) begin
      if (!we && addr == 2'd2) n_srd++;
      if (n_acc == 0) begin first_is_srd = !we && addr == 2'd2; first_rd_val = rdata; end
      if (n_acc == 1) begin second_is_swr = we && addr == 2'd2; wb_val = wdata; end
      n_acc++;
    end
  end

  int n_checks = 0, n_fail = 0, cycles = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int pw(input int s);
    return (s < POLL_LIMIT) ? s + 1 : POLL_LIMIT;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // runs one transaction; optionally pulses a stray start while busy
  task automatic run(input logic [7:0] op, input logic [3:0] ni, input logic [3:0] no,
                     input logic [63:0] a, input int txs, input int rxs,
                     input logic [63:0] rb, input bit stray);
    tx_stall = txs; rx_stall = rxs;
    rxq[0] = ACK;
    for (int k = 0; k < 16; k++) rxq[k+1] = (k < 8) ? rb[8*k +: 8] : 8'h00;
    clear_log();
    opcode = op; in_cnt = ni; out_cnt = no; args = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", 64'(busy), 64'd1);
    if (stray) begin
      repeat (3) @(negedge clk);
      opcode = 8'hEE; in_cnt = 4'd1; out_cnt = 4'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 30000 && busy; w++) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R11", "busy after end", 64'(busy), 64'd0);
    chk(n_done == 1, "R11", "done pulses", 64'(n_done), 64'd1);
  endtask

  task automatic check_txn(input string tag, input logic [7:0] op, input int ni,
                           input int no, input logic [63:0] a, input int txs,
                           input int rxs, input logic [63:0] rb);
    logic [63:0] er;
    bit ok;
    chk(first_is_srd && second_is_swr && wb_val == first_rd_val, "R2",
        {tag, " clear write-back"}, 64'(wb_val), 64'(first_rd_val));
    chk(n_dwr == ni + 1, "R4", {tag, " data writes"}, 64'(n_dwr), 64'(ni + 1));
    chk(dwr[0] == {16'h0, op, 8'h00}, "R3", {tag, " opcode word"}, 64'(dwr[0]),
        64'({16'h0, op, 8'h00}));
    ok = 1;
    for (int k = 0; k < ni; k++) if (dwr[k+1] != {16'h0, a[8*k +: 8], 8'h00}) ok = 0;
    chk(ok, "R4", {tag, " argument order"}, 64'(dwr[1]), 64'({16'h0, a[7:0], 8'h00}));
    chk(n_drd == no + 1 && n_clr4 == no + 1, "R6", {tag, " reads and clears"},
        64'(n_drd * 256 + n_clr4), 64'((no + 1) * 256 + no + 1));
    chk(n_swr_other == 1, "R6", {tag, " other status writes"}, 64'(n_swr_other), 64'd1);
    chk(n_srd == 1 + (1 + ni) * pw(txs) + (1 + no) * pw(rxs), "R5",
        {tag, " status reads"}, 64'(n_srd), 64'(1 + (1 + ni) * pw(txs) + (1 + no) * pw(rxs)));
    er = '0;
    for (int k = 0; k < no; k++) er[8*k +: 8] = rb[8*k +: 8];
    chk(resp == er, "R8", {tag, " response bytes"}, resp, er);
    chk(sword == {er[7:0], er[15:8]}, "R9", {tag, " status word"}, 64'(sword),
        64'({er[7:0], er[15:8]}));
  endtask

  initial begin
    for (int k = 0; k < 32; k++) begin rxq[k] = 8'h00; dwr[k] = '0; end
    do_reset();
    chk(!busy && !done && !timeout && !req, "R1", "reset outputs",
        64'({busy, done, timeout, req}), 64'd0);
    chk(resp == '0 && sword == '0, "R1", "reset results", resp, 64'd0);

    for (int v = 0; v < NV; v++) begin
      run(V_OP[v], V_NIN[v], V_NOUT[v], V_ARGS[v], V_TXS[v], V_RXS[v], V_RESP[v], 1'b0);
      check_txn($sformatf("vec%0d", v), V_OP[v], (V_NIN[v] > 8) ? 8 : int'(V_NIN[v]),
                (V_NOUT[v] > 8) ? 8 : int'(V_NOUT[v]), V_ARGS[v], V_TXS[v], V_RXS[v],
                V_RESP[v]);
      if (v == 3) chk(n_dwr == 9 && n_drd == 9, "R12", "saturated counts",
                      64'(n_dwr * 256 + n_drd), 64'(9 * 256 + 9));
      chk(timeout == 1'b0, "R5", "no timeout on short waits", 64'(timeout), 64'd0);
    end

    // stray start while busy (R10)
    run(8'h0C, 4'd0, 4'd2, 64'h0, 2, 1, 64'h0000_0000_0000_4321, 1'b1);
    check_txn("stray start R10", 8'h0C, 0, 2, 64'h0, 2, 1, 64'h0000_0000_0000_4321);
    chk(busy == 1'b0 && n_dwr == 1, "R10", "no second transaction",
        64'(n_dwr), 64'd1);

    // transmit wait runs out (R5)
    run(8'h42, 4'd0, 4'd0, 64'h0, 20000, 0, 64'h0, 1'b0);
    chk(n_srd == 2 + POLL_LIMIT, "R5", "tx poll bound", 64'(n_srd), 64'(2 + POLL_LIMIT));
    chk(n_dwr == 1 && dwr[0] == 32'h0000_4200, "R5", "write after expiry",
        64'(dwr[0]), 64'h4200);
    chk(timeout == 1'b1, "R5", "timeout set", 64'(timeout), 64'd1);

    // sticky across a clean transaction
    run(8'h11, 4'd0, 4'd2, 64'h0, 0, 0, 64'h0000_0000_0000_0201, 1'b0);
    chk(timeout == 1'b1, "R5", "timeout sticky", 64'(timeout), 64'd1);

    // receive wait runs out (R7)
    do_reset();
    chk(timeout == 1'b0 && resp == '0, "R1", "reset clears timeout", 64'(timeout), 64'd0);
    run(8'h30, 4'd0, 4'd0, 64'h0, 0, 20000, 64'h0, 1'b0);
    chk(n_srd == 2 + POLL_LIMIT, "R7", "rx poll bound", 64'(n_srd), 64'(2 + POLL_LIMIT));
    chk(n_drd == 1 && n_clr4 == 1, "R7", "read after expiry", 64'(n_drd), 64'd1);
    chk(timeout == 1'b1, "R7", "timeout set", 64'(timeout), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule